// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block is a direct-mapped cache of branch targets that sits beside instruction fetch. Each cycle the fetch stage presents its current program counter. The buffer selects one entry with a slice of that address and compares the stored tag against every remaining address bit. Only when the entry is valid and the whole address matches does it report a hit. On a hit it returns the predicted next-fetch address and, when the instruction-storage option is enabled, the first instruction word found at that target. Fetch can then redirect at once instead of waiting for the branch target to be computed.

When a branch resolves, the execution side writes through the update port. A taken branch installs its entry, replacing whatever branch held that slot before. A not-taken branch that currently owns its slot removes the entry. Lookup is purely combinational from the registered storage, so an update becomes visible on the cycle after it is presented.

Top module: `btb_cache`

## Requirements
- R1: After reset every entry is invalid, and no lookup hits until a taken update has been written.
- R2: The entry index is PC bits [ADDR_LSB+IDX_W-1 : ADDR_LSB], which are bits [5:2] by default. The tag is every other PC bit, including bits below ADDR_LSB, so two PCs that differ only in their lowest bits do not share a hit.
- R3: `lk_hit` is 1 exactly when the indexed entry is valid and its tag equals the tag of `lk_pc`. On a hit, `lk_target` carries the stored target.
- R4: A lookup PC with the same index as a stored entry but a different tag misses.
- R5: An update with `up_valid`=1 and `up_taken`=1 writes valid, tag, target and instruction word into the entry at `up_pc`'s index, replacing any previous occupant. Other entries are unchanged.
- R6: An update with `up_valid`=1 and `up_taken`=0 whose full PC matches the valid entry at its index invalidates that entry.
- R7: A not-taken update whose PC does not match the stored entry leaves that entry unchanged.
- R8: An update is not visible to a lookup in the same cycle. It is visible from the next cycle on.
- R9: With STORE_INSTR=1, `lk_instr` returns the stored instruction word on a hit. With STORE_INSTR=0 it is always 0.
- R10: On a miss, `lk_target` and `lk_instr` are 0.
- R11: While `up_valid`=0, the update inputs have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid bits |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Valid entry with full address match |
| lk_target | output | PC_W | Predicted next-fetch address (0 on miss) |
| lk_instr | output | INSTR_W | Instruction word at the target (0 on miss or when not stored) |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | 1 installs the entry; 0 removes a matching entry |
| up_target | input | PC_W | Resolved target address |
| up_instr | input | INSTR_W | Instruction word at the resolved target |

## Verification
Lookup results are combinational, so each is due in the same cycle its `lk_pc` is applied. An update takes effect at the next rising edge and shows up on the following lookup. The bench applies lookup and update together at the falling edge and compares the outputs shortly after it, against a model that still holds the state from before that update. It then applies the update to the model, so that the next comparison, made after the rising edge, expects the new contents.

// File: rtl/btb_pkg.sv
package btb_pkg;
   typedef enum logic [1:0] {
      BTB_HOLD = 2'd0,
      BTB_FILL = 2'd1,
      BTB_KILL = 2'd2
   } btb_act_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
   parameter int PC_W     = 32,
   parameter int IDX_W    = 4,
   parameter int ADDR_LSB = 2,
   localparam int TAG_W   = PC_W - IDX_W
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   localparam int IDX_HI = ADDR_LSB + IDX_W;

   assign idx = pc[IDX_HI-1:ADDR_LSB];

   generate
      if (ADDR_LSB == 0) begin : g_no_low
         assign tag = pc[PC_W-1:IDX_HI];
      end else begin : g_low
         assign tag = {pc[PC_W-1:IDX_HI], pc[ADDR_LSB-1:0]};
      end
   endgenerate
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
   import btb_pkg::*;
#(
   parameter int TAG_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid,
   input  logic             up_taken,
   input  logic [TAG_W-1:0] up_tag,
   input  logic             cur_valid,
   input  logic [TAG_W-1:0] cur_tag,
   output btb_act_e         act
);
   logic owns_slot;
   assign owns_slot = cur_valid && (cur_tag == up_tag);

   always_comb begin
      act = BTB_HOLD;
      if (up_valid) begin
         if (up_taken)       act = BTB_FILL;
         else if (owns_slot) act = BTB_KILL;
      end
   end

   // R6 / R7: removal happens only for a matching not-taken branch
   p_kill_only_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act == BTB_KILL) |-> (up_valid && !up_taken && cur_valid && cur_tag == up_tag));
   // R11: no action without the update strobe
   p_idle_without_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |-> (act == BTB_HOLD));
endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
   import btb_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int IDX_W       = 4,
   parameter int INSTR_W     = 32,
   parameter bit STORE_INSTR = 1'b1,
   localparam int TAG_W      = PC_W - IDX_W,
   localparam int DEPTH      = 1 << IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic               rd_valid,
   output logic [TAG_W-1:0]   rd_tag,
   output logic [PC_W-1:0]    rd_tgt,
   output logic [INSTR_W-1:0] rd_instr,
   input  logic [IDX_W-1:0]   wr_idx,
   output logic               cur_valid,
   output logic [TAG_W-1:0]   cur_tag,
   input  btb_act_e           wr_act,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [PC_W-1:0]    wr_tgt,
   input  logic [INSTR_W-1:0] wr_instr
);
   logic [DEPTH-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q [DEPTH];
   logic [PC_W-1:0]   tgt_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_act == BTB_FILL) begin
         valid_q[wr_idx] <= 1'b1;
      end else if (wr_act == BTB_KILL) begin
         valid_q[wr_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_act == BTB_FILL) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_tgt;
      end
   end

   assign rd_valid  = valid_q[rd_idx];
   assign rd_tag    = tag_q[rd_idx];
   assign rd_tgt    = tgt_q[rd_idx];
   assign cur_valid = valid_q[wr_idx];
   assign cur_tag   = tag_q[wr_idx];

   generate
      if (STORE_INSTR) begin : g_instr
         logic [INSTR_W-1:0] instr_q [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_act == BTB_FILL) instr_q[wr_idx] <= wr_instr;
         end
         assign rd_instr = instr_q[rd_idx];
      end else begin : g_no_instr
         assign rd_instr = '0;
      end
   endgenerate

   // R5: entries not addressed by an active write keep their valid bit
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_chk
         p_other_entries_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_act != BTB_HOLD && wr_idx == IDX_W'(i)) |=> (valid_q[i] == $past(valid_q[i])));
      end
   endgenerate
endmodule

// File: rtl/btb_cache.sv
module btb_cache
   import btb_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int IDX_W       = 4,
   parameter int ADDR_LSB    = 2,
   parameter int INSTR_W     = 32,
   parameter bit STORE_INSTR = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PC_W-1:0]    lk_pc,
   output logic               lk_hit,
   output logic [PC_W-1:0]    lk_target,
   output logic [INSTR_W-1:0] lk_instr,
   input  logic               up_valid,
   input  logic [PC_W-1:0]    up_pc,
   input  logic               up_taken,
   input  logic [PC_W-1:0]    up_target,
   input  logic [INSTR_W-1:0] up_instr
);
   localparam int TAG_W = PC_W - IDX_W;

   generate
      if (IDX_W < 1 || ADDR_LSB < 0 || ADDR_LSB + IDX_W >= PC_W) begin : g_bad_geom
         initial $fatal(1, "btb_cache: index field does not fit the PC width");
      end
      if (INSTR_W < 1) begin : g_bad_instr
         initial $fatal(1, "btb_cache: INSTR_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]   lk_idx, up_idx;
   logic [TAG_W-1:0]   lk_tag, up_tag;
   logic               rd_valid, cur_valid;
   logic [TAG_W-1:0]   rd_tag, cur_tag;
   logic [PC_W-1:0]    rd_tgt;
   logic [INSTR_W-1:0] rd_instr;
   btb_act_e           act;

   btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ADDR_LSB(ADDR_LSB)) u_lk_split (
      .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

   btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ADDR_LSB(ADDR_LSB)) u_up_split (
      .pc(up_pc), .idx(up_idx), .tag(up_tag));

   btb_entry_array #(.PC_W(PC_W), .IDX_W(IDX_W), .INSTR_W(INSTR_W),
                     .STORE_INSTR(STORE_INSTR)) u_array (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
      .rd_tgt(rd_tgt), .rd_instr(rd_instr),
      .wr_idx(up_idx), .cur_valid(cur_valid), .cur_tag(cur_tag),
      .wr_act(act), .wr_tag(up_tag), .wr_tgt(up_target), .wr_instr(up_instr));

   btb_update_ctl #(.TAG_W(TAG_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_taken(up_taken), .up_tag(up_tag),
      .cur_valid(cur_valid), .cur_tag(cur_tag), .act(act));

   assign lk_hit    = rd_valid && (rd_tag == lk_tag);
   assign lk_target = lk_hit ? rd_tgt : '0;
   assign lk_instr  = lk_hit ? rd_instr : '0;

   // R1: the first cycle after reset sees an empty buffer
   p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !lk_hit);
   // R5 / R8: a taken update is seen by a lookup of the same PC on the next cycle
   p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(up_valid && up_taken) && lk_pc == $past(up_pc))
      |-> (lk_hit && lk_target == $past(up_target)));
   // R6: a not-taken update leaves its own PC missing afterwards
   p_kill_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(up_valid && !up_taken) && lk_pc == $past(up_pc)) |-> !lk_hit);
endmodule

// File: tb/tb_btb_cache.sv
module tb_btb_cache;
   localparam int PC_W  = 32;
   localparam int IW    = 32;
   localparam int NENT  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
   logic [IW-1:0]   up_instr = '0;
   logic          up_valid = 1'b0, up_taken = 1'b0;
   logic          lk_hit;
   logic [PC_W-1:0] lk_target;
   logic [IW-1:0]   lk_instr;

   int checks = 0;
   int errors = 0;

   logic            m_v   [NENT];
   logic [PC_W-1:0] m_pc  [NENT];
   logic [PC_W-1:0] m_tgt [NENT];
   logic [IW-1:0]   m_ins [NENT];

   always #4 clk = ~clk;

   btb_cache dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
      .lk_target(lk_target), .lk_instr(lk_instr), .up_valid(up_valid),
      .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target), .up_instr(up_instr));

   function automatic int idx_of(input logic [PC_W-1:0] pc);
      return int'(pc[5:2]);
   endfunction

   function automatic logic model_hit(input logic [PC_W-1:0] pc);
      return m_v[idx_of(pc)] && (m_pc[idx_of(pc)] == pc);
   endfunction

   function automatic logic [PC_W-1:0] pool_pc(input int k);
      return (PC_W'(k / 6 + 1) << 16) | (PC_W'(k % 6) << 2);
   endfunction

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic [PC_W-1:0] lpc, input logic uv,
                       input logic [PC_W-1:0] upc, input logic ut,
                       input logic [PC_W-1:0] utg, input logic [IW-1:0] uin,
                       input string req);
      logic eh;
      logic [PC_W-1:0] et;
      logic [IW-1:0] ei;
      int i;
      @(negedge clk);
      lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
      up_target = utg; up_instr = uin;
      #1;
      eh = model_hit(lpc);
      et = eh ? m_tgt[idx_of(lpc)] : '0;
      ei = eh ? m_ins[idx_of(lpc)] : '0;
      chk(lk_hit == eh, req, "hit", 64'(lk_hit), 64'(eh));
      chk(lk_target == et, req, "target (R10 on miss)", 64'(lk_target), 64'(et));
      chk(lk_instr == ei, req, "instr R9", 64'(lk_instr), 64'(ei));
      if (uv) begin
         i = idx_of(upc);
         if (ut) begin
            m_v[i] = 1'b1; m_pc[i] = upc; m_tgt[i] = utg; m_ins[i] = uin;
         end else if (m_v[i] && m_pc[i] == upc) begin
            m_v[i] = 1'b0;
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [PC_W-1:0] pa, pb;
      void'($urandom(32'd20240611));
      for (int k = 0; k < NENT; k++) m_v[k] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      for (int k = 0; k < 6; k++) step(pool_pc(k), 1'b0, '0, 1'b0, '0, '0, "R1");

      pa = 32'h0001_0010;   // index 4
      pb = 32'h0002_0010;   // same index, other tag
      // R8: fill and lookup in the same cycle -> miss, then hit
      step(pa, 1'b1, pa, 1'b1, 32'hCAFE_0100, 32'h1111_AAAA, "R8");
      step(pa, 1'b0, '0, 1'b0, '0, '0, "R5/R3");
      // R4: alias at same index misses
      step(pb, 1'b0, '0, 1'b0, '0, '0, "R4");
      // R2: low bits are part of the tag
      step(pa | 32'h1, 1'b0, '0, 1'b0, '0, '0, "R2");
      // R7: not-taken alias leaves entry
      step(pa, 1'b1, pb, 1'b0, 32'hDEAD_0000, 32'h0, "R7");
      step(pa, 1'b0, '0, 1'b0, '0, '0, "R7");
      // R11: strobe low ignored
      step(pa, 1'b0, pa, 1'b0, '0, '0, "R11");
      step(pa, 1'b0, pb, 1'b1, 32'h5555_0000, 32'h7, "R11");
      step(pb, 1'b0, '0, 1'b0, '0, '0, "R11");
      step(pa, 1'b0, '0, 1'b0, '0, '0, "R11");
      // R5: alias replaces occupant
      step(pb, 1'b1, pb, 1'b1, 32'hBEEF_0200, 32'h2222_BBBB, "R5");
      step(pa, 1'b0, '0, 1'b0, '0, '0, "R5");
      step(pb, 1'b0, '0, 1'b0, '0, '0, "R5");
      // R6: matching not-taken removes
      step(pb, 1'b1, pb, 1'b0, '0, '0, "R6");
      step(pb, 1'b0, '0, 1'b0, '0, '0, "R6");

      // random traffic over a small aliasing address pool
      for (int n = 0; n < 600; n++) begin
         step(pool_pc(int'($urandom % 24)), ($urandom % 4) != 0,
              pool_pc(int'($urandom % 24)), ($urandom % 3) != 0,
              $urandom, $urandom, "R3");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule